// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDR SDRAM from power-on to a usable state. After reset it turns on the memory clock enable. It then waits out the required stabilisation time and issues the fixed start-up command series: one precharge of every bank, a run of auto-refresh cycles, and a load of the mode register. Each command is followed by its own minimum settling interval. When the last interval has elapsed, the block raises a ready flag and hands the command pins over to normal operation. From then on it drives only NOPs.

Once ready, the block runs a periodic refresh timer. A down-counter is loaded from a programmable interval input. Each time the counter expires, the block emits a one-cycle refresh request for the memory controller to act on. All waits are set by parameters: the clock frequency in MHz, the stabilisation time in microseconds, the precharge delay, the row cycle time, the mode-register delay and the number of start-up refreshes.

The mode word is fixed. It selects single-beat bursts, sequential ordering, CAS latency 3, standard operation and single-location writes.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While rst_n is low, cke is 0, {cs_n,ras_n,cas_n,we_n} is the NOP code 4'b0111, addr and ba are 0, and both init_done and refresh_req are 0.
- R2: cke rises on the third rising clock edge after rst_n is released, because the reset passes through a two-stage release synchronizer. cke then stays high. Before cke rises, no command other than NOP appears.
- R3: The first command after cke rises is PRECHARGE ALL (code 4'b0010). It appears exactly CLK_MHZ*WAIT_US cycles after cke rises, which is 9000 cycles by default, and addr bit 10 is 1 while it is on the bus.
- R4: The first AUTO REFRESH (code 4'b0001) appears T_RP cycles after the precharge (2 by default). Exactly REF_CYCLES refreshes are issued (8 by default), each T_RC cycles after the one before it (7 by default).
- R5: LOAD MODE (code 4'b0000) appears T_RC cycles after the last refresh, with ba = 2'b00 and addr = 12'h230. In that word, bits [2:0]=000 select burst length 1, bit 3=0 selects sequential order, bits [6:4]=011 select CAS latency 3, bits [8:7]=00 select standard mode, and bit 9=1 selects single-location writes.
- R6: In every cycle that is not one of the commands above, the pins carry the NOP code 4'b0111. No other code ever appears.
- R7: init_done rises T_MRD cycles after LOAD MODE (2 by default) and stays high until reset. After that the block issues only NOPs.
- R8: refresh_req is low before init_done. Its first one-cycle pulse comes refresh_count cycles after init_done rises, and further pulses follow every refresh_count cycles. refresh_count must be at least 1.
- R9: refresh_count is sampled only when the timer reloads, that is, when init_done rises and at each pulse. A change takes effect from the interval that follows the next pulse.
- R10: Asserting rst_n in the middle of the sequence returns every output to its R1 state at once. After release, the full sequence restarts from the beginning with the same spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, same as the SDRAM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_count | input | REF_W | Refresh interval in clock cycles, must be 1 or more |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus; carries bit 10 for precharge-all and the mode word |
| ba | output | BA_W | Bank address |
| init_done | output | 1 | High once the start-up sequence has completed |
| refresh_req | output | 1 | One-cycle periodic refresh request |

## Verification
The assertions take two things for granted. First, rst_n is the only control input. Second, refresh_count is never zero while the refresh timer runs, since a zero interval would make the timer wrap to its maximum value instead of producing a defined period. The stimulus only ever applies refresh intervals of 50 and 20 cycles. It changes the interval only between two pulses, and it asserts reset mid-sequence only after the command stream has already been observed to reach the refresh phase.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_PWAIT,
    ST_TRP,
    ST_TRC,
    ST_TMRD,
    ST_DONE
  } state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  // Strobe levels for each command
  function automatic pins_t cmd_pins(cmd_e c);
    pins_t p;
    case (c)
      CMD_PRE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_MRS: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

  // Mode register word assembled from its fields
  function automatic logic [15:0] mode_word(input logic [2:0] burst_code,
                                            input logic       interleave,
                                            input logic [2:0] cas_lat,
                                            input logic [1:0] op_mode,
                                            input logic       single_wr);
    logic [15:0] w;
    w        = '0;
    w[2:0]   = burst_code;
    w[3]     = interleave;
    w[6:4]   = cas_lat;
    w[8:7]   = op_mode;
    w[9]     = single_wr;
    return w;
  endfunction

endpackage

// File: rtl/seq_reset_sync.sv
module seq_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage1_q   <= 1'b1;
      rst_sync_n <= stage1_q;
    end
  end
endmodule

// File: rtl/seq_delay_cnt.sv
module seq_delay_cnt #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/seq_cmd_drive.sv
module seq_cmd_drive
  import sdram_seq_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter int          BA_W    = 2,
  parameter int          A10_POS = 10,
  parameter logic [15:0] MODE    = 16'h0230
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_next,
  input  cmd_e              cmd_next,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);
  pins_t             pins_d, pins_q;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    pins_d = cmd_pins(cmd_next);
    addr_d = '0;
    case (cmd_next)
      CMD_PRE: addr_d[A10_POS] = 1'b1;
      CMD_MRS: addr_d = MODE[ADDR_W-1:0];
      default: addr_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke    <= 1'b0;
      pins_q <= cmd_pins(CMD_NOP);
      addr   <= '0;
      ba     <= '0;
    end else begin
      cke    <= cke_next;
      pins_q <= pins_d;
      addr   <= addr_d;
      ba     <= '0;
    end
  end

  assign cs_n  = pins_q.cs_n;
  assign ras_n = pins_q.ras_n;
  assign cas_n = pins_q.cas_n;
  assign we_n  = pins_q.we_n;
endmodule

// File: rtl/seq_refresh_tmr.sv
module seq_refresh_tmr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] period,
  output logic         req
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         req_d;

  always_comb begin
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (load) begin
      cnt_d = period - 1'b1;
    end else if (run) begin
      if (cnt_q == '0) begin
        req_d = 1'b1;
        cnt_d = period - 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req   <= req_d;
    end
  end
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_seq_pkg::*;
#(
  parameter int CLK_MHZ    = 90,
  parameter int WAIT_US    = 100,
  parameter int T_RP       = 2,
  parameter int T_RC       = 7,
  parameter int T_MRD      = 2,
  parameter int REF_CYCLES = 8,
  parameter int CAS_LAT    = 3,
  parameter int ADDR_W     = 12,
  parameter int BA_W       = 2,
  parameter int REF_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REF_W-1:0]  refresh_count,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              init_done,
  output logic              refresh_req
);
  localparam int PWR_CYC = CLK_MHZ * WAIT_US;
  localparam int MAX_A   = (PWR_CYC > T_RC) ? PWR_CYC : T_RC;
  localparam int MAX_B   = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAX_DLY = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int DLY_W   = $clog2(MAX_DLY + 1);
  localparam int RN_W    = $clog2(REF_CYCLES + 1);
  localparam logic [15:0] MODE =
    mode_word(3'b000, 1'b0, 3'(CAS_LAT), 2'b00, 1'b1);

  logic             rst_i_n;
  state_e           st_q, st_d;
  cmd_e             cmd_d;
  logic [RN_W-1:0]  refn_q, refn_d;
  logic             done_q, done_d;
  logic             dly_load, dly_zero, tmr_load;
  logic [DLY_W-1:0] dly_val;

  seq_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  seq_delay_cnt #(.W(DLY_W)) u_dly (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (dly_load),
    .load_val (dly_val),
    .zero     (dly_zero)
  );

  // Next-state process
  always_comb begin
    st_d     = st_q;
    cmd_d    = CMD_NOP;
    refn_d   = refn_q;
    done_d   = done_q;
    dly_load = 1'b0;
    dly_val  = '0;
    tmr_load = 1'b0;
    case (st_q)
      ST_RESET: begin
        dly_load = 1'b1;
        dly_val  = DLY_W'(PWR_CYC - 1);
        st_d     = ST_PWAIT;
      end
      ST_PWAIT: if (dly_zero) begin
        cmd_d    = CMD_PRE;
        dly_load = 1'b1;
        dly_val  = DLY_W'(T_RP - 1);
        st_d     = ST_TRP;
      end
      ST_TRP: if (dly_zero) begin
        cmd_d    = CMD_REF;
        dly_load = 1'b1;
        dly_val  = DLY_W'(T_RC - 1);
        refn_d   = RN_W'(1);
        st_d     = ST_TRC;
      end
      ST_TRC: if (dly_zero) begin
        dly_load = 1'b1;
        if (refn_q == RN_W'(REF_CYCLES)) begin
          cmd_d   = CMD_MRS;
          dly_val = DLY_W'(T_MRD - 1);
          st_d    = ST_TMRD;
        end else begin
          cmd_d   = CMD_REF;
          dly_val = DLY_W'(T_RC - 1);
          refn_d  = refn_q + 1'b1;
        end
      end
      ST_TMRD: if (dly_zero) begin
        done_d   = 1'b1;
        tmr_load = 1'b1;
        st_d     = ST_DONE;
      end
      default: st_d = ST_DONE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_RESET;
      refn_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      refn_q <= refn_d;
      done_q <= done_d;
    end
  end

  seq_cmd_drive #(
    .ADDR_W  (ADDR_W),
    .BA_W    (BA_W),
    .A10_POS (10),
    .MODE    (MODE)
  ) u_drv (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cke_next (1'b1),
    .cmd_next (cmd_d),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .addr     (addr),
    .ba       (ba)
  );

  seq_refresh_tmr #(.W(REF_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .load   (tmr_load),
    .run    (done_q),
    .period (refresh_count),
    .req    (refresh_req)
  );

  assign init_done = done_q;
endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
  parameter int ADDR_W     = 12,
  parameter int BA_W       = 2,
  parameter int REF_CYCLES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic              init_done,
  input logic              refresh_req
);
  localparam int RC_W = $clog2(REF_CYCLES + 1) + 1;
  localparam logic [ADDR_W-1:0] EXP_MODE = ADDR_W'(10'h230);

  logic [3:0] code;
  logic       is_nop, is_pre, is_ref, is_mrs;
  logic [RC_W-1:0] refs_seen;

  assign code   = {cs_n, ras_n, cas_n, we_n};
  assign is_nop = (code == 4'b0111);
  assign is_pre = (code == 4'b0010);
  assign is_ref = (code == 4'b0001);
  assign is_mrs = (code == 4'b0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      refs_seen <= '0;
    else if (is_ref) refs_seen <= refs_seen + 1'b1;
  end

  // R2
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
  // R2
  no_cmd_before_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> is_nop);
  // R3
  pre_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> addr[10]);
  // R4
  ref_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (refs_seen < RC_W'(REF_CYCLES)));
  // R5
  mrs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (addr == EXP_MODE && ba == '0 && refs_seen == RC_W'(REF_CYCLES)));
  // R6
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop || is_pre || is_ref || is_mrs);
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  // R7
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> is_nop);
  // R8
  req_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> init_done);
endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
  .ADDR_W     (ADDR_W),
  .BA_W       (BA_W),
  .REF_CYCLES (REF_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cke         (cke),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .addr        (addr),
  .ba          (ba),
  .init_done   (init_done),
  .refresh_req (refresh_req)
);

// File: tb/sdram_pwrup_seq_tb.sv
module sdram_pwrup_seq_tb;
  localparam int PWR   = 90 * 100;
  localparam int TRP   = 2;
  localparam int TRC   = 7;
  localparam int TMRD  = 2;
  localparam int NEV   = 12;
  localparam int K_CKE = 0, K_PRE = 1, K_REF = 2, K_MRS = 3, K_DONE = 4;
  localparam int EXP_KIND [NEV] = '{K_CKE, K_PRE, K_REF, K_REF, K_REF, K_REF,
                                     K_REF, K_REF, K_REF, K_REF, K_MRS, K_DONE};
  localparam int EXP_GAP  [NEV] = '{0, PWR, TRP, TRC, TRC, TRC, TRC, TRC,
                                     TRC, TRC, TRC, TMRD};

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] refresh_count;
  logic        cke, cs_n, ras_n, cas_n, we_n, init_done, refresh_req;
  logic [11:0] addr;
  logic [1:0]  ba;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sdram_pwrup_seq u_dut (
    .clk(clk), .rst_n(rst_n), .refresh_count(refresh_count),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .init_done(init_done), .refresh_req(refresh_req)
  );

  // Command stream recorder
  longint cyc = 0;
  int     ev_n, rq_n, bad_cmd, post_cmd, early_req, wide_req, done_drop;
  int     ev_kind [32];
  longint ev_cyc  [32];
  longint rq_cyc  [16];
  logic   pre_a10;
  logic [11:0] mrs_addr;
  logic [1:0]  mrs_ba;
  logic   prev_cke, prev_done, prev_req;

  task automatic log_ev(input int k);
    if (ev_n < 32) begin
      ev_kind[ev_n] = k;
      ev_cyc[ev_n]  = cyc;
    end
    ev_n++;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      ev_n = 0; rq_n = 0; bad_cmd = 0; post_cmd = 0; early_req = 0;
      wide_req = 0; done_drop = 0; prev_cke = 0; prev_done = 0; prev_req = 0;
    end else begin
      if (cke && !prev_cke) log_ev(K_CKE);
      if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
        if (init_done) post_cmd++;
        if (!cke) bad_cmd++;
        case ({cs_n, ras_n, cas_n, we_n})
          4'b0010: begin log_ev(K_PRE); pre_a10 = addr[10]; end
          4'b0001: log_ev(K_REF);
          4'b0000: begin log_ev(K_MRS); mrs_addr = addr; mrs_ba = ba; end
          default: bad_cmd++;
        endcase
      end
      if (init_done && !prev_done) log_ev(K_DONE);
      if (prev_done && !init_done) done_drop++;
      if (refresh_req) begin
        if (!init_done) early_req++;
        if (prev_req) wide_req++;
        if (rq_n < 16) rq_cyc[rq_n] = cyc;
        rq_n++;
      end
      prev_cke = cke; prev_done = init_done; prev_req = refresh_req;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int k);
    case (k)
      K_CKE:   return "R2 cke event";
      K_PRE:   return "R3 precharge";
      K_REF:   return "R4 refresh";
      K_MRS:   return "R5 mode load";
      default: return "R7 done";
    endcase
  endfunction

  task automatic wait_done();
    for (int n = 0; n < 20000 && !init_done; n++) @(negedge clk);
    @(negedge clk);
  endtask

  // Walk the expected command table
  task automatic walk_table(input string run);
    chk(ev_n == NEV, "R4 event count", ev_n, NEV);
    for (int i = 0; i < NEV; i++) begin
      chk(ev_kind[i] == EXP_KIND[i], tag_of(EXP_KIND[i]), ev_kind[i], EXP_KIND[i]);
      if (i > 0)
        chk(ev_cyc[i] - ev_cyc[i-1] == EXP_GAP[i], tag_of(EXP_KIND[i]),
            ev_cyc[i] - ev_cyc[i-1], EXP_GAP[i]);
    end
    chk(pre_a10 == 1'b1, "R3 A10 high", pre_a10, 1);
    chk(mrs_addr == 12'h230, "R5 mode word", mrs_addr, 12'h230);
    chk(mrs_ba == 2'b00, "R5 bank", mrs_ba, 0);
    chk(bad_cmd == 0, "R6 illegal or early code", bad_cmd, 0);
    $display("table walk %s done", run);
  endtask

  task automatic check_reset_state(input string req);
    chk(cke == 1'b0, req, cke, 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, req, {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(addr == '0 && ba == '0, req, {addr, ba}, 0);
    chk(init_done == 1'b0 && refresh_req == 1'b0, req, {init_done, refresh_req}, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    refresh_count = 16'd50;
    repeat (3) @(negedge clk);
    check_reset_state("R1 reset state");

    // R2: release timing through the synchronizer
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(cke == 1'b0, "R2 cke before third edge", cke, 0);
    @(negedge clk);
    chk(cke == 1'b1, "R2 cke at third edge", cke, 1);

    wait_done();
    walk_table("run1");

    // R8 / R9: refresh period and reprogramming
    for (int n = 0; n < 400 && rq_n < 2; n++) @(negedge clk);
    chk(rq_n >= 2, "R8 pulses seen", rq_n, 2);
    chk(rq_cyc[0] - ev_cyc[NEV-1] == 50, "R8 first period", rq_cyc[0] - ev_cyc[NEV-1], 50);
    chk(rq_cyc[1] - rq_cyc[0] == 50, "R8 period", rq_cyc[1] - rq_cyc[0], 50);
    refresh_count = 16'd20;
    for (int n = 0; n < 400 && rq_n < 4; n++) @(negedge clk);
    chk(rq_cyc[2] - rq_cyc[1] == 50, "R9 current interval kept", rq_cyc[2] - rq_cyc[1], 50);
    chk(rq_cyc[3] - rq_cyc[2] == 20, "R9 new interval", rq_cyc[3] - rq_cyc[2], 20);
    chk(wide_req == 0 && early_req == 0, "R8 pulse width and gating", wide_req + early_req, 0);
    chk(post_cmd == 0, "R7 quiet after done", post_cmd, 0);
    chk(done_drop == 0 && init_done, "R7 done held", done_drop, 0);

    // R10: reset in the middle of the refresh phase
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int n = 0; n < 20000 && ev_n < 6; n++) @(negedge clk);
    chk(ev_n == 6 && ev_kind[5] == K_REF, "R10 reached refresh phase", ev_n, 6);
    rst_n = 1'b0;
    #1;
    check_reset_state("R10 async return to reset");
    @(negedge clk);
    rst_n = 1'b1;
    wait_done();
    walk_table("run2");
    for (int n = 0; n < 100 && rq_n < 1; n++) @(negedge clk);
    chk(rq_n >= 1 && rq_cyc[0] - ev_cyc[NEV-1] == 20, "R10 refresh after restart",
        rq_cyc[0] - ev_cyc[NEV-1], 20);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule